// File: doc/BRIEF.md
# Stepped Soft-Start Current-Limit Controller

This block sets the switch current limit of a boost converter while it starts up. When a start request arrives, it selects the lowest of four current-limit levels. It then raises the level by one step each time a fixed number of switching cycles passes, stopping at the full limit. An analog comparator and a small DAC outside this block turn the 2-bit level code into a trip current. Each step adds about a quarter of full scale.

If the converter output reports that it is in regulation before the timed steps finish, the controller goes straight to the full limit. It then holds that level until the start request is withdrawn. Withdrawing the start request at any time aborts the sequence and returns the block to idle.

The phase length is counted in switching cycles, not clock cycles. A clock enable that pulses once per switching period drives the count. With the default of 1024 cycles per phase and a 1 MHz switching rate, each timed phase lasts about 1 ms. The whole ramp to full limit therefore spans 3072 switching cycles.

Top module: `sstart_ilim_ctrl`

## Requirements
- R1: While reset is high, and on the first cycle after it, `ilim_code` is 0 and `ss_done` is 0.
- R2: With `start_req` low the block is idle with `ilim_code` 0. The clock edge that first samples `start_req` high enters phase one, and `ilim_code` stays 0 (the lowest level).
- R3: The level codes are 0, 1 and 2 for the three timed phases and 3 for the full limit. Each timed phase lasts exactly PHASE_CYCLES enabled cycles, after which `ilim_code` rises by exactly one. While `start_req` stays high the code never decreases.
- R4: If `in_reg` is high on a cycle when `start_req` is high and was already high on the previous cycle, the next edge sets `ilim_code` to 3 and `ss_done` to 1, whatever phase the block is in.
- R5: `ss_done` is 1 exactly when `ilim_code` is 3.
- R6: Once the full limit is reached, `ilim_code` stays 3 and `ss_done` stays 1 while `start_req` is high, even if `in_reg` falls.
- R7: When `start_req` is sampled low, the next edge gives `ilim_code` 0 and `ss_done` 0. The phase counter is also cleared, so a new start times a full PH1 again.
- R8: The phase counter only advances on cycles where `sw_en` is high. With `sw_en` low the code does not change unless `in_reg` or `start_req` forces it.
- R9: Without regulation, and with `sw_en` always high, the full limit is reached exactly 3*PHASE_CYCLES edges after the edge that entered phase one.
- R10: `in_reg` has no effect while `start_req` is low; `ilim_code` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Start request; low aborts to idle |
| in_reg | input | 1 | Converter output is in regulation |
| sw_en | input | 1 | One-cycle enable per switching period |
| ilim_code | output | 2 | Current-limit level, 0 = lowest, 3 = full |
| ss_done | output | 1 | Full limit reached |

## Verification
The main sequence is driven with `sw_en` held high, so that the edge on which each level rises can be predicted exactly and any off-by-one error in phase length shows up. It is also driven with `sw_en` held low for long stretches, which shows whether the timer counts clock cycles instead of switching periods.

Regulation is raised during a timed phase to check the jump to full limit, and raised while idle to check that it is ignored. It is then dropped after the full limit is reached, to check that the level is held.

Two aborts are run: one in the middle of a phase and one after full limit. In each case a restart must take a complete first phase, which shows whether a leftover count survives the abort.

// File: rtl/sstart_pkg.sv
package sstart_pkg;

  localparam int unsigned LVL_W = 2;

  typedef enum logic [2:0] {
    SS_IDLE = 3'd0,
    SS_PH1  = 3'd1,
    SS_PH2  = 3'd2,
    SS_PH3  = 3'd3,
    SS_FULL = 3'd4
  } ss_state_e;

  // Level code presented to the current-limit DAC for each state.
  function automatic logic [LVL_W-1:0] level_of(ss_state_e s);
    logic [LVL_W-1:0] lv;
    case (s)
      SS_PH2:  lv = LVL_W'(1);
      SS_PH3:  lv = LVL_W'(2);
      SS_FULL: lv = LVL_W'(3);
      default: lv = LVL_W'(0);
    endcase
    return lv;
  endfunction

  function automatic logic is_timed(ss_state_e s);
    return (s == SS_PH1) || (s == SS_PH2) || (s == SS_PH3);
  endfunction

endpackage

// File: rtl/sstart_cycle_timer.sv
module sstart_cycle_timer #(
  parameter int unsigned PHASE_CYCLES = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic tick,
  output logic expire
);
  localparam int unsigned CNT_W = (PHASE_CYCLES > 1) ? $clog2(PHASE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PHASE_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  assign expire = tick && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (tick) begin
      if (cnt_q == LAST) cnt_q <= '0;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sstart_phase_seq.sv
module sstart_phase_seq
  import sstart_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      start_req,
  input  logic      in_reg,
  input  logic      expire,
  output ss_state_e state_q,
  output ss_state_e state_d
);
  always_comb begin
    state_d = state_q;
    if (!start_req) begin
      state_d = SS_IDLE;
    end else begin
      case (state_q)
        SS_IDLE: state_d = SS_PH1;
        SS_PH1:  state_d = in_reg ? SS_FULL : (expire ? SS_PH2 : SS_PH1);
        SS_PH2:  state_d = in_reg ? SS_FULL : (expire ? SS_PH3 : SS_PH2);
        SS_PH3:  state_d = (in_reg || expire) ? SS_FULL : SS_PH3;
        SS_FULL: state_d = SS_FULL;
        default: state_d = SS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= SS_IDLE;
    else     state_q <= state_d;
  end
endmodule

// File: rtl/sstart_level_out.sv
module sstart_level_out
  import sstart_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  ss_state_e        state_d,
  output logic [LVL_W-1:0] code_q,
  output logic             done_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
      done_q <= 1'b0;
    end else begin
      code_q <= level_of(state_d);
      done_q <= (state_d == SS_FULL);
    end
  end
endmodule

// File: rtl/sstart_ilim_ctrl.sv
module sstart_ilim_ctrl
  import sstart_pkg::*;
#(
  parameter int unsigned PHASE_CYCLES = 1024
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_req,
  input  logic             in_reg,
  input  logic             sw_en,
  output logic [LVL_W-1:0] ilim_code,
  output logic             ss_done
);
  ss_state_e state_q, state_d;
  logic      timed, tmr_clr, tmr_tick, tmr_expire;

  assign timed    = is_timed(state_q);
  assign tmr_clr  = !timed || !start_req;
  assign tmr_tick = timed && sw_en;

  sstart_cycle_timer #(.PHASE_CYCLES(PHASE_CYCLES)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .clr    (tmr_clr),
    .tick   (tmr_tick),
    .expire (tmr_expire)
  );

  sstart_phase_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .start_req (start_req),
    .in_reg    (in_reg),
    .expire    (tmr_expire),
    .state_q   (state_q),
    .state_d   (state_d)
  );

  sstart_level_out u_out (
    .clk     (clk),
    .rst     (rst),
    .state_d (state_d),
    .code_q  (ilim_code),
    .done_q  (ss_done)
  );
endmodule

// File: rtl/sstart_ilim_ctrl_chk.sv
module sstart_ilim_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       start_req,
  input logic       in_reg,
  input logic       sw_en,
  input logic [1:0] ilim_code,
  input logic       ss_done
);
  a_r5_done_means_full: assert property (@(posedge clk) disable iff (rst)
    ss_done |-> (ilim_code == 2'd3));

  a_r7_abort_to_idle: assert property (@(posedge clk) disable iff (rst)
    !start_req |=> (ilim_code == 2'd0) && !ss_done);

  a_r6_full_held: assert property (@(posedge clk) disable iff (rst)
    (ss_done && start_req) |=> ss_done);

  a_r4_early_exit: assert property (@(posedge clk) disable iff (rst)
    (start_req && in_reg && $past(start_req) && !$past(rst)) |=> ss_done);

  a_r3_no_decrease: assert property (@(posedge clk) disable iff (rst)
    start_req |=> (ilim_code >= $past(ilim_code)));

  a_r3_single_step: assert property (@(posedge clk) disable iff (rst)
    (start_req && !in_reg) |=>
      ((ilim_code == $past(ilim_code)) || (ilim_code == $past(ilim_code) + 2'd1)));

  a_r8_hold_without_enable: assert property (@(posedge clk) disable iff (rst)
    (start_req && !in_reg && !sw_en) |=> $stable(ilim_code));

  a_r10_idle_ignores_reg: assert property (@(posedge clk) disable iff (rst)
    (!start_req && in_reg) |=> (ilim_code == 2'd0));
endmodule

bind sstart_ilim_ctrl sstart_ilim_ctrl_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .start_req (start_req),
  .in_reg    (in_reg),
  .sw_en     (sw_en),
  .ilim_code (ilim_code),
  .ss_done   (ss_done)
);

// File: tb/sstart_ilim_ctrl_tb_top.sv
`timescale 1ns/1ps
module sstart_ilim_ctrl_tb_top;
  localparam int unsigned PC = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_req = 1'b0;
  logic       in_reg = 1'b0;
  logic       sw_en = 1'b1;
  logic [1:0] ilim_code;
  logic       ss_done;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  finished = 1'b0;

  always #2.5 clk = ~clk;

  sstart_ilim_ctrl #(.PHASE_CYCLES(PC)) dut_i (
    .clk(clk), .rst(rst), .start_req(start_req), .in_reg(in_reg),
    .sw_en(sw_en), .ilim_code(ilim_code), .ss_done(ss_done)
  );

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic check(input string req, input int act_code, input int exp_code,
                       input int act_done, input int exp_done);
    n_tests++;
    if (act_code != exp_code || act_done != exp_done) begin
      n_fail++;
      $display("FAIL %s: code=%0d done=%0d expected code=%0d done=%0d",
               req, act_code, act_done, exp_code, exp_done);
    end
  endtask

  task automatic t_reset;
    rst = 1'b1; start_req = 1'b1; in_reg = 1'b1;
    step(3);
    check("R1 during reset", ilim_code, 0, ss_done, 0);
    start_req = 1'b0; in_reg = 1'b0; rst = 1'b0;
    step(1);
    check("R1 after reset", ilim_code, 0, ss_done, 0);
  endtask

  task automatic t_idle_reg;
    in_reg = 1'b1;
    step(5);
    check("R10 in_reg while idle", ilim_code, 0, ss_done, 0);
    in_reg = 1'b0;
    step(1);
  endtask

  task automatic t_phases;
    start_req = 1'b1; sw_en = 1'b1;
    step(1);
    check("R2 phase one entered", ilim_code, 0, ss_done, 0);
    step(PC - 1);
    check("R3 end of phase one", ilim_code, 0, ss_done, 0);
    step(1);
    check("R3 phase two", ilim_code, 1, ss_done, 0);
    step(PC);
    check("R3 phase three", ilim_code, 2, ss_done, 0);
    step(PC - 1);
    check("R9 one before full", ilim_code, 2, ss_done, 0);
    step(1);
    check("R9 R5 full reached", ilim_code, 3, ss_done, 1);
    start_req = 1'b0;
    step(1);
    check("R7 abort after full", ilim_code, 0, ss_done, 0);
  endtask

  task automatic t_gated;
    start_req = 1'b1; sw_en = 1'b0;
    step(1);
    step(3 * PC);
    check("R8 no count without enable", ilim_code, 0, ss_done, 0);
    sw_en = 1'b1;
    step(PC - 1);
    check("R8 enabled count partial", ilim_code, 0, ss_done, 0);
    step(1);
    check("R8 enabled count complete", ilim_code, 1, ss_done, 0);
    start_req = 1'b0;
    step(1);
  endtask

  task automatic t_early_and_hold;
    start_req = 1'b1; sw_en = 1'b1;
    step(1 + PC + 2);
    check("R3 in phase two", ilim_code, 1, ss_done, 0);
    in_reg = 1'b1;
    step(1);
    check("R4 early exit", ilim_code, 3, ss_done, 1);
    in_reg = 1'b0;
    step(4 * PC);
    check("R6 full held after reg drops", ilim_code, 3, ss_done, 1);
    start_req = 1'b0;
    step(1);
  endtask

  task automatic t_abort_restart;
    start_req = 1'b1; sw_en = 1'b1;
    step(1 + PC / 2);
    start_req = 1'b0;
    step(1);
    check("R7 abort mid phase", ilim_code, 0, ss_done, 0);
    start_req = 1'b1;
    step(1);
    step(PC - 1);
    check("R7 counter cleared", ilim_code, 0, ss_done, 0);
    step(1);
    check("R7 fresh phase length", ilim_code, 1, ss_done, 0);
    start_req = 1'b0;
    step(1);
  endtask

  initial begin
    t_reset();
    t_idle_reg();
    t_phases();
    t_gated();
    t_early_and_hold();
    t_abort_restart();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule